// File: doc/BRIEF.md
# Display Bridge Power-Up Sequencer

This block is a hardware state machine that takes a parallel-to-serial display bridge from power-on reset to streaming video. It drives the reset pin of the bridge and times every delay with an external one-microsecond tick. Each register access goes out through a register-access port, such as a serial master, using a request/done handshake. If a readback path exists, the sequencer first confirms the bridge identity. It then writes the video timing, pixel format, lane count, mode, PLL and clock settings, and sends two panel commands. Last, it switches the data lanes to high speed and enables video.

All display timings, the pixel depth, the lane count, the PLL word, the low-power divider and the two command delays are static configuration inputs. Computing those values and framing the serial traffic are left to other blocks. The sequencer keeps a private copy of the bridge mode register. It changes single bits of that copy at fixed points in the sequence and rewrites the whole copy each time. The result is reported on two sticky flags, `ready` and `error`.

The states and their transitions:

| State | Transition |
|---|---|
| ST_HOLD | Drives the bridge reset pin low. Goes to ST_SETTLE when the timer expires. |
| ST_SETTLE | Goes to ST_RD_ID when readback is enabled, or to ST_VALIDATE when it is not. |
| ST_RD_ID | Reads the identity register. Goes to ST_RD_CFG on a match, or to ST_FAULT on a mismatch. |
| ST_RD_CFG | Reads the mode register. Goes to ST_VALIDATE on a match, or to ST_FAULT on a mismatch. |
| ST_VALIDATE | Goes to ST_CFG_WR when the pixel depth is supported, or to ST_FAULT when it is not. |
| ST_CFG_WR | Steps through twelve writes. Goes to ST_PLL_WAIT after the last one. |
| ST_PLL_WAIT | Goes to ST_CMD_LEN when the timer expires. |
| ST_CMD_LEN | Goes to ST_CMD_CODE when its write completes. |
| ST_CMD_CODE | Goes to ST_CMD_WAIT when its write completes. |
| ST_CMD_WAIT | Returns to ST_CMD_LEN after the first command, or goes to ST_FINAL after the second. |
| ST_FINAL | Goes to ST_READY when its write completes. |
| ST_READY | Terminal state. |
| ST_FAULT | Terminal state. |

Top module: `dbridge_pwrseq`

## Requirements
- R1: After reset, `bridge_rst_n` stays low for exactly RST_LOW_US ticks and then stays high. The first access starts exactly RST_WAIT_US ticks after the pin rises. No access is issued while the pin is low.
- R2: With `readback_en` high, the first two accesses are reads (`acc_write`=0). The first reads address 0xB0 and must return 0x2828. The second reads address 0xB7 and must return 0x0301. A mismatch on either read ends the sequence in `error`, with no further access. With `readback_en` low, no read is issued.
- R3: Supported `px_depth` values are 16, 18 and 24. Any other value ends the sequence in `error` before any write is issued.
- R4: The first five writes set the video timing. Each value is written as {vertical byte, horizontal byte}, except where noted:
  - 0xB1 gets the sync widths.
  - 0xB2 gets sync width plus back porch, each sum taken modulo 256.
  - 0xB3 gets the front porches.
  - 0xB4 gets `h_active`, written as a whole 16-bit value.
  - 0xB5 gets `v_active`, written as a whole 16-bit value.
- R5: 0xB6 is written with 0x0008 OR a format code. The code is 0 for 16 bpp, 1 for packed 18 bpp, 2 for 18 bpp with `px_loose`=1, and 3 for 24 bpp.
- R6: 0xDE is written with `lane_count`-1.
- R7: 0xB7 is then written with the mode copy. The copy starts at 0x0301. Bit 0 is cleared, bits 1 and 6 are set, and bit 5 is set when `pclk_ref` is high. The result is 0x0342, or 0x0362 when `pclk_ref` is high.
- R8: Four writes follow, in this order:
  - `pll_word` to 0xBA
  - 0 to 0xB8
  - (`lp_div`-1) mod 64 to 0xBB
  - 1 to 0xB9

  The next access starts exactly PLL_WAIT_US ticks after the last of these writes completes.
- R9: Each panel command is two writes: 1 to 0xBC, then the command byte to 0xBF. Exit-sleep (0x11) is sent first, then display-on (0x29). After exit-sleep, the next access waits exactly `exit_sleep_ms`×US_PER_MS ticks. After display-on, it waits exactly `display_on_ms`×US_PER_MS ticks.
- R10: The last write sets bits 0 and 3 of the mode copy at 0xB7, giving 0x034B or 0x036B. `ready` rises once that write completes.
- R11: `acc_req` and its address, data and direction stay stable until `acc_done`. Each `acc_done` ends exactly one transfer, and the next transfer may begin in the following cycle.
- R12: `ready` and `error` are never high together. Once either is set, it stays set and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| readback_en | input | 1 | The access port can return read data |
| hsync_len | input | 8 | Horizontal sync width |
| vsync_len | input | 8 | Vertical sync width |
| hback | input | 8 | Horizontal back porch, sync excluded |
| vback | input | 8 | Vertical back porch, sync excluded |
| hfront | input | 8 | Horizontal front porch |
| vfront | input | 8 | Vertical front porch |
| h_active | input | RESW | Active pixels per line |
| v_active | input | RESW | Active lines per frame |
| px_depth | input | 5 | Bits per pixel |
| px_loose | input | 1 | 18 bpp uses the loosely packed format |
| lane_count | input | 3 | Number of data lanes, 1 to 4 |
| pclk_ref | input | 1 | PLL reference is the pixel clock |
| pll_word | input | 16 | Precomputed PLL setting |
| lp_div | input | 7 | Low-power clock divider |
| exit_sleep_ms | input | MSW | Delay after exit-sleep, in ms |
| display_on_ms | input | MSW | Delay after display-on, in ms |
| acc_done | input | 1 | Current transfer complete |
| acc_rdata | input | 16 | Read data, valid with `acc_done` |
| bridge_rst_n | output | 1 | Bridge reset pin, active low |
| acc_req | output | 1 | Transfer request |
| acc_write | output | 1 | 1 for a write, 0 for a read |
| acc_addr | output | 8 | Register address |
| acc_wdata | output | 16 | Write data |
| ready | output | 1 | Bridge streaming video |
| error | output | 1 | Sequence aborted |

## Verification
The bench sweeps every pixel format with each lane count from one to four and both PLL reference choices. For each combination it derives porch, resolution, divider and delay values, some of which make the back-porch sums wrap past 255. It then compares the complete ordered list of transfers, including the tick count before each one, with a list built independently in the bench. This separates errors in field packing, format encoding, bit placement in the mode copy and wait lengths, including zero-length waits.

Further runs cover the failure and bypass paths:
- a wrong identity value
- a wrong mode-register value
- two unsupported depths, with readback on and with readback off
- readback disabled

These runs confirm that each failure ends the sequence at the correct transfer and that the bypass path skips both reads.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

    typedef enum logic [3:0] {
        ST_HOLD, ST_SETTLE, ST_RD_ID, ST_RD_CFG, ST_VALIDATE, ST_CFG_WR,
        ST_PLL_WAIT, ST_CMD_LEN, ST_CMD_CODE, ST_CMD_WAIT, ST_FINAL,
        ST_READY, ST_FAULT
    } seq_state_e;

    localparam int STEP_W = 4;
    localparam logic [STEP_W-1:0] STEP_MODE = 4'd7;
    localparam logic [STEP_W-1:0] STEP_LAST = 4'd11;

    localparam logic [7:0]  REG_ID       = 8'hB0;
    localparam logic [7:0]  REG_MODE     = 8'hB7;
    localparam logic [7:0]  REG_CMD_LEN  = 8'hBC;
    localparam logic [7:0]  REG_CMD_DATA = 8'hBF;
    localparam logic [15:0] ID_EXPECT    = 16'h2828;
    localparam logic [15:0] MODE_RESET   = 16'h0301;

    localparam logic [7:0]  CMD_EXIT_SLEEP = 8'h11;
    localparam logic [7:0]  CMD_DISPLAY_ON = 8'h29;

    // single-bit masks of the bridge mode register
    localparam logic [15:0] MODE_HS       = 16'h0001;
    localparam logic [15:0] MODE_CLK_HS   = 16'h0002;
    localparam logic [15:0] MODE_VIDEO    = 16'h0008;
    localparam logic [15:0] MODE_PCLK_REF = 16'h0020;
    localparam logic [15:0] MODE_CMD_ONLY = 16'h0040;

    function automatic logic depth_ok(input logic [4:0] depth);
        return (depth == 5'd16) || (depth == 5'd18) || (depth == 5'd24);
    endfunction

    function automatic logic [1:0] fmt_code(input logic [4:0] depth, input logic loose);
        logic [1:0] c;
        case (depth)
            5'd18:   c = loose ? 2'd2 : 2'd1;
            5'd24:   c = 2'd3;
            default: c = 2'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dbp_us_timer.sv
module dbp_us_timer #(
    parameter int TW   = 32,
    parameter int INIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= TW'(INIT);
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R1: an expired timer never wraps without a reload
    assert_timer_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/dbp_cfg_table.sv
module dbp_cfg_table
    import dbp_pkg::*;
#(
    parameter int RESW = 16
) (
    input  logic [STEP_W-1:0] step,
    input  logic [7:0]        hsync_len,
    input  logic [7:0]        vsync_len,
    input  logic [7:0]        hback,
    input  logic [7:0]        vback,
    input  logic [7:0]        hfront,
    input  logic [7:0]        vfront,
    input  logic [RESW-1:0]   h_active,
    input  logic [RESW-1:0]   v_active,
    input  logic [1:0]        fmt,
    input  logic [2:0]        lane_count,
    input  logic [15:0]       pll_word,
    input  logic [6:0]        lp_div,
    input  logic [15:0]       mode_in,
    output logic [7:0]        addr,
    output logic [15:0]       data
);
    logic [7:0] h_bp_total, v_bp_total;
    logic [5:0] lp_field;
    logic [2:0] lane_field;

    assign h_bp_total = hsync_len + hback;
    assign v_bp_total = vsync_len + vback;
    assign lp_field   = 6'(lp_div - 7'd1);
    assign lane_field = lane_count - 3'd1;

    always_comb begin
        unique case (step)
            4'd0:    begin addr = 8'hB1; data = {vsync_len, hsync_len}; end
            4'd1:    begin addr = 8'hB2; data = {v_bp_total, h_bp_total}; end
            4'd2:    begin addr = 8'hB3; data = {vfront, hfront}; end
            4'd3:    begin addr = 8'hB4; data = 16'(h_active); end
            4'd4:    begin addr = 8'hB5; data = 16'(v_active); end
            4'd5:    begin addr = 8'hB6; data = {12'h000, 2'b10, fmt}; end
            4'd6:    begin addr = 8'hDE; data = {13'h0000, lane_field}; end
            4'd7:    begin
                         addr = REG_MODE;
                         data = (mode_in & ~MODE_HS) | MODE_CLK_HS | MODE_CMD_ONLY;
                     end
            4'd8:    begin addr = 8'hBA; data = pll_word; end
            4'd9:    begin addr = 8'hB8; data = 16'h0000; end
            4'd10:   begin addr = 8'hBB; data = {10'h000, lp_field}; end
            4'd11:   begin addr = 8'hB9; data = 16'h0001; end
            default: begin addr = 8'h00; data = 16'h0000; end
        endcase
    end

endmodule

// File: rtl/dbridge_pwrseq.sv
module dbridge_pwrseq
    import dbp_pkg::*;
#(
    parameter int RST_LOW_US  = 10000,
    parameter int RST_WAIT_US = 10000,
    parameter int PLL_WAIT_US = 500,
    parameter int US_PER_MS   = 1000,
    parameter int MSW         = 16,
    parameter int RESW        = 16,
    parameter int TW          = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            us_tick,
    input  logic            readback_en,
    input  logic [7:0]      hsync_len,
    input  logic [7:0]      vsync_len,
    input  logic [7:0]      hback,
    input  logic [7:0]      vback,
    input  logic [7:0]      hfront,
    input  logic [7:0]      vfront,
    input  logic [RESW-1:0] h_active,
    input  logic [RESW-1:0] v_active,
    input  logic [4:0]      px_depth,
    input  logic            px_loose,
    input  logic [2:0]      lane_count,
    input  logic            pclk_ref,
    input  logic [15:0]     pll_word,
    input  logic [6:0]      lp_div,
    input  logic [MSW-1:0]  exit_sleep_ms,
    input  logic [MSW-1:0]  display_on_ms,
    input  logic            acc_done,
    input  logic [15:0]     acc_rdata,
    output logic            bridge_rst_n,
    output logic            acc_req,
    output logic            acc_write,
    output logic [7:0]      acc_addr,
    output logic [15:0]     acc_wdata,
    output logic            ready,
    output logic            error
);
    seq_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              cmd_q, cmd_d;
    logic [15:0]       mode_q, mode_d;

    logic              tmr_load, tmr_expired;
    logic [TW-1:0]     tmr_val;
    logic [7:0]        tbl_addr;
    logic [15:0]       tbl_data;

    dbp_us_timer #(.TW(TW), .INIT(RST_LOW_US)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dbp_cfg_table #(.RESW(RESW)) u_table (
        .step       (step_q),
        .hsync_len  (hsync_len),
        .vsync_len  (vsync_len),
        .hback      (hback),
        .vback      (vback),
        .hfront     (hfront),
        .vfront     (vfront),
        .h_active   (h_active),
        .v_active   (v_active),
        .fmt        (fmt_code(px_depth, px_loose)),
        .lane_count (lane_count),
        .pll_word   (pll_word),
        .lp_div     (lp_div),
        .mode_in    (mode_q),
        .addr       (tbl_addr),
        .data       (tbl_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            step_q  <= '0;
            cmd_q   <= 1'b0;
            mode_q  <= MODE_RESET;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            cmd_q   <= cmd_d;
            mode_q  <= mode_d;
        end
    end

    // next-state, mode copy updates and timer loads
    always_comb begin
        state_d  = state_q;
        step_d   = step_q;
        cmd_d    = cmd_q;
        mode_d   = mode_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_HOLD: if (tmr_expired) begin
                state_d  = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = TW'(RST_WAIT_US);
            end
            ST_SETTLE: if (tmr_expired)
                state_d = readback_en ? ST_RD_ID : ST_VALIDATE;
            ST_RD_ID: if (acc_done)
                state_d = (acc_rdata == ID_EXPECT) ? ST_RD_CFG : ST_FAULT;
            ST_RD_CFG: if (acc_done)
                state_d = (acc_rdata == MODE_RESET) ? ST_VALIDATE : ST_FAULT;
            ST_VALIDATE: begin
                if (depth_ok(px_depth)) begin
                    state_d = ST_CFG_WR;
                    step_d  = '0;
                    if (pclk_ref) mode_d = mode_q | MODE_PCLK_REF;
                end else begin
                    state_d = ST_FAULT;
                end
            end
            ST_CFG_WR: if (acc_done) begin
                if (step_q == STEP_MODE) mode_d = tbl_data;
                if (step_q == STEP_LAST) begin
                    state_d  = ST_PLL_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PLL_WAIT_US);
                end else begin
                    step_d = step_q + 1'b1;
                end
            end
            ST_PLL_WAIT: if (tmr_expired) begin
                state_d = ST_CMD_LEN;
                cmd_d   = 1'b0;
            end
            ST_CMD_LEN: if (acc_done) state_d = ST_CMD_CODE;
            ST_CMD_CODE: if (acc_done) begin
                state_d  = ST_CMD_WAIT;
                tmr_load = 1'b1;
                tmr_val  = cmd_q ? TW'(display_on_ms) * TW'(US_PER_MS)
                                 : TW'(exit_sleep_ms) * TW'(US_PER_MS);
            end
            ST_CMD_WAIT: if (tmr_expired) begin
                if (!cmd_q) begin
                    cmd_d   = 1'b1;
                    state_d = ST_CMD_LEN;
                end else begin
                    state_d = ST_FINAL;
                end
            end
            ST_FINAL: if (acc_done) begin
                mode_d  = mode_q | MODE_HS | MODE_VIDEO;
                state_d = ST_READY;
            end
            ST_READY: state_d = ST_READY;
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_FAULT;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        acc_req   = 1'b0;
        acc_write = 1'b1;
        acc_addr  = 8'h00;
        acc_wdata = 16'h0000;
        unique case (state_q)
            ST_RD_ID:    begin acc_req = 1'b1; acc_write = 1'b0; acc_addr = REG_ID; end
            ST_RD_CFG:   begin acc_req = 1'b1; acc_write = 1'b0; acc_addr = REG_MODE; end
            ST_CFG_WR:   begin acc_req = 1'b1; acc_addr = tbl_addr; acc_wdata = tbl_data; end
            ST_CMD_LEN:  begin acc_req = 1'b1; acc_addr = REG_CMD_LEN; acc_wdata = 16'h0001; end
            ST_CMD_CODE: begin
                acc_req   = 1'b1;
                acc_addr  = REG_CMD_DATA;
                acc_wdata = {8'h00, cmd_q ? CMD_DISPLAY_ON : CMD_EXIT_SLEEP};
            end
            ST_FINAL:    begin
                acc_req   = 1'b1;
                acc_addr  = REG_MODE;
                acc_wdata = mode_q | MODE_HS | MODE_VIDEO;
            end
            default:     acc_req = 1'b0;
        endcase
    end

    assign bridge_rst_n = (state_q != ST_HOLD);
    assign ready        = (state_q == ST_READY);
    assign error        = (state_q == ST_FAULT);

    assert_no_access_in_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_rst_n |-> !acc_req);

    assert_pin_stays_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_rst_n |=> bridge_rst_n);

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_done) |=> (acc_req && $stable(acc_addr) && $stable(acc_wdata)
                                    && $stable(acc_write)));

    assert_outcome_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && error));

    assert_outcome_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ready || error) |=> ($stable(ready) && $stable(error) && !acc_req));

    assert_ready_after_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(acc_req && acc_done && acc_addr == REG_MODE));

endmodule

// File: tb/sim_dbridge_pwrseq.sv
module sim_dbridge_pwrseq;
    localparam int LOW = 6, SETTLE = 5, PLLW = 7, UPM = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, us_tick = 1'b0, readback_en = 1'b1;
    logic [7:0] hsync_len = 0, vsync_len = 0, hback = 0, vback = 0, hfront = 0, vfront = 0;
    logic [15:0] h_active = 0, v_active = 0, pll_word = 0;
    logic [4:0] px_depth = 5'd16;
    logic px_loose = 0, pclk_ref = 0;
    logic [2:0] lane_count = 3'd1;
    logic [6:0] lp_div = 7'd1;
    logic [15:0] exit_sleep_ms = 0, display_on_ms = 0;
    logic acc_done = 1'b0;
    logic [15:0] acc_rdata = 0;
    logic bridge_rst_n, acc_req, acc_write, ready, error;
    logic [7:0] acc_addr;
    logic [15:0] acc_wdata;

    dbridge_pwrseq #(.RST_LOW_US(LOW), .RST_WAIT_US(SETTLE), .PLL_WAIT_US(PLLW),
                     .US_PER_MS(UPM)) u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .readback_en(readback_en),
        .hsync_len(hsync_len), .vsync_len(vsync_len), .hback(hback), .vback(vback),
        .hfront(hfront), .vfront(vfront), .h_active(h_active), .v_active(v_active),
        .px_depth(px_depth), .px_loose(px_loose), .lane_count(lane_count),
        .pclk_ref(pclk_ref), .pll_word(pll_word), .lp_div(lp_div),
        .exit_sleep_ms(exit_sleep_ms), .display_on_ms(display_on_ms),
        .acc_done(acc_done), .acc_rdata(acc_rdata), .bridge_rst_n(bridge_rst_n),
        .acc_req(acc_req), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .ready(ready), .error(error));

    int checks = 0, errors = 0;

    int e_addr[32], e_wr[32], e_data[32], e_pre[32];
    string e_tag[32];
    int e_n;
    bit e_ready;
    string e_end_tag;

    int o_addr[32], o_wr[32], o_data[32], o_pre[32];
    bit o_bad[32];
    int o_n;

    bit busy, seen_rel;
    int lat, win, low_ticks, tcnt;
    logic [15:0] id_resp, cfg_resp;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int a, input int w, input int d, input int p, input string t);
        e_addr[e_n] = a; e_wr[e_n] = w; e_data[e_n] = d; e_pre[e_n] = p; e_tag[e_n] = t;
        e_n++;
    endtask

    task automatic step_cycle;
        bit tk, dn;
        @(negedge clk);
        tk = us_tick;
        dn = acc_done;
        if (rst_n && !bridge_rst_n) low_ticks += int'(tk);
        if (dn) begin
            acc_done = 1'b0;
            win = 0;
        end else if (!seen_rel) begin
            if (bridge_rst_n) begin seen_rel = 1; win = 0; end
        end else if (!acc_req && !busy) begin
            win += int'(tk);
        end
        if (busy && o_n > 0) begin
            if (!acc_req || int'(acc_addr) != o_addr[o_n-1] || int'(acc_write) != o_wr[o_n-1]
                || int'(acc_wdata) != o_data[o_n-1])
                o_bad[o_n-1] = 1;
        end
        if (acc_req && !busy && o_n < 32) begin
            o_addr[o_n] = int'(acc_addr); o_wr[o_n] = int'(acc_write);
            o_data[o_n] = int'(acc_wdata); o_pre[o_n] = win; o_bad[o_n] = 0;
            lat = o_n % 3;
            busy = 1;
            o_n++;
        end
        if (busy) begin
            if (lat == 0) begin
                acc_done  = 1'b1;
                acc_rdata = (o_addr[o_n-1] == 'hB0) ? id_resp : cfg_resp;
                busy = 0;
            end else lat--;
        end
        us_tick = (tcnt % 4 == 3);
        tcnt++;
    endtask

    task automatic do_case(input int depth, input bit loose, input int lanes, input bit pref,
                           input bit rb, input logic [15:0] idr, input logic [15:0] cfr,
                           input int seed);
        int hs, vs, hb, vb, hf, vf, ha, va, pw, lp, ex, on, fmt, mid, extra;
        bit depth_good;
        hs = 2 + seed % 7;    vs = 1 + lanes;
        hb = 240 + seed % 29; vb = 250 + (seed * 3) % 11;
        hf = 10 + seed % 5;   vf = 3 + seed % 4;
        ha = 320 + seed * 37; va = 200 + seed * 11;
        pw = 'h4000 + seed * 'h123;
        lp = (seed * 9) % 66;
        ex = seed % 3;        on = (seed / 2) % 2;

        readback_en = rb; hsync_len = 8'(hs); vsync_len = 8'(vs); hback = 8'(hb);
        vback = 8'(vb); hfront = 8'(hf); vfront = 8'(vf); h_active = 16'(ha);
        v_active = 16'(va); px_depth = 5'(depth); px_loose = loose;
        lane_count = 3'(lanes); pclk_ref = pref; pll_word = 16'(pw); lp_div = 7'(lp);
        exit_sleep_ms = 16'(ex); display_on_ms = 16'(on);
        id_resp = idr; cfg_resp = cfr;

        // expected transfer list
        depth_good = (depth == 16) || (depth == 18) || (depth == 24);
        fmt = (depth == 24) ? 3 : (depth == 18) ? (loose ? 2 : 1) : 0;
        mid = 'h0342 | (pref ? 'h20 : 0);
        e_n = 0; e_ready = 0;
        e_end_tag = "R12";
        if (rb) begin
            push('hB0, 0, 0, SETTLE, "R2");
            if (idr != 16'h2828) e_end_tag = "R2";
            else begin
                push('hB7, 0, 0, 0, "R2");
                if (cfr != 16'h0301) e_end_tag = "R2";
            end
        end
        if (e_end_tag == "R12") begin
            if (!depth_good) e_end_tag = "R3";
            else begin
                push('hB1, 1, (vs << 8) | hs, rb ? 0 : SETTLE, "R4");
                push('hB2, 1, (((vs + vb) & 255) << 8) | ((hs + hb) & 255), 0, "R4");
                push('hB3, 1, (vf << 8) | hf, 0, "R4");
                push('hB4, 1, ha & 'hFFFF, 0, "R4");
                push('hB5, 1, va & 'hFFFF, 0, "R4");
                push('hB6, 1, 8 | fmt, 0, "R5");
                push('hDE, 1, lanes - 1, 0, "R6");
                push('hB7, 1, mid, 0, "R7");
                push('hBA, 1, pw & 'hFFFF, 0, "R8");
                push('hB8, 1, 0, 0, "R8");
                push('hBB, 1, (lp - 1) & 63, 0, "R8");
                push('hB9, 1, 1, 0, "R8");
                push('hBC, 1, 1, PLLW, "R9");
                push('hBF, 1, 'h11, 0, "R9");
                push('hBC, 1, 1, ex * UPM, "R9");
                push('hBF, 1, 'h29, 0, "R9");
                push('hB7, 1, mid | 'h9, on * UPM, "R10");
                e_ready = 1; e_end_tag = "R10";
            end
        end

        // reset and run
        rst_n = 1'b0; acc_done = 1'b0; us_tick = 1'b0; tcnt = 0;
        o_n = 0; busy = 0; seen_rel = 0; win = 0; low_ticks = 0;
        repeat (3) @(negedge clk);
        chk(!bridge_rst_n && !acc_req && !ready && !error, "R1", "reset state",
            int'({bridge_rst_n, acc_req, ready, error}), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 3000; c++) begin
            step_cycle();
            if ((ready || error) && !busy && !acc_done) break;
        end
        extra = 0;
        for (int c = 0; c < 12; c++) begin
            step_cycle();
            if (acc_req) extra++;
        end

        chk(low_ticks == LOW, "R1", "ticks with reset pin low", low_ticks, LOW);
        chk(o_n == e_n, e_end_tag, "transfer count", o_n, e_n);
        for (int i = 0; i < e_n && i < o_n; i++) begin
            chk(o_addr[i] == e_addr[i], e_tag[i], $sformatf("addr of transfer %0d", i),
                o_addr[i], e_addr[i]);
            chk(o_wr[i] == e_wr[i], e_tag[i], $sformatf("direction of transfer %0d", i),
                o_wr[i], e_wr[i]);
            if (e_wr[i] == 1)
                chk(o_data[i] == e_data[i], e_tag[i], $sformatf("data of transfer %0d", i),
                    o_data[i], e_data[i]);
            chk(o_pre[i] == e_pre[i], (i == 0) ? "R1" : e_tag[i],
                $sformatf("ticks before transfer %0d", i), o_pre[i], e_pre[i]);
            chk(!o_bad[i], "R11", $sformatf("request held for transfer %0d", i),
                int'(o_bad[i]), 0);
        end
        chk(ready == e_ready && error == !e_ready, e_end_tag, "final ready/error",
            int'({ready, error}), int'({e_ready, !e_ready}));
        chk(extra == 0, "R12", "requests after outcome", extra, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s;
        s = 0;
        // sweep of formats, lanes and PLL reference with good readback
        for (int d = 0; d < 4; d++)
            for (int l = 1; l <= 4; l++)
                for (int p = 0; p < 2; p++) begin
                    do_case((d == 0) ? 16 : (d == 3) ? 24 : 18, d == 2, l, p[0], 1'b1,
                            16'h2828, 16'h0301, s);
                    s++;
                end
        // readback disabled path
        do_case(24, 1'b0, 2, 1'b1, 1'b0, 16'h0000, 16'h0000, 5);
        do_case(18, 1'b1, 3, 1'b0, 1'b0, 16'h0000, 16'h0000, 12);
        // identity and mode readback failures
        do_case(16, 1'b0, 1, 1'b0, 1'b1, 16'h2827, 16'h0301, 3);
        do_case(16, 1'b0, 1, 1'b0, 1'b1, 16'h2828, 16'h0300, 4);
        // unsupported depths
        do_case(20, 1'b0, 2, 1'b0, 1'b1, 16'h2828, 16'h0301, 6);
        do_case(0, 1'b0, 2, 1'b0, 1'b0, 16'h2828, 16'h0301, 7);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule